// File: doc/BRIEF.md
# Predicated Execution and Status Flag Unit

This block keeps the processor's four status flags (negative, zero, carry, overflow) and decides, one instruction slot at a time, whether the instruction in that slot is allowed to take effect. Each instruction arrives with a 4-bit condition code, a flag-update bit and a compare-class marker. The block evaluates the code against the stored flags once, when the slot is accepted. It then holds an execute-enable and a register-write enable for the rest of the slot, which the datapath uses to gate its register and memory writes. The slot ends when the datapath raises its end-of-execute strobe. At that edge the ALU flag outputs are copied into the flag register, but only if the instruction passed its condition and either has its flag-update bit set or is a compare.

An instruction that fails its condition still occupies a full slot, so fetch and sequencing go on unchanged. It writes nothing and leaves the flags as they were. Compare-class operations (compare by subtraction, by addition, by AND or by XOR) always update the flags when they pass and never write a result register.

The slot control is a two-state machine. `SLOT_IDLE` waits for an instruction. The transition *accept* (issue high in `SLOT_IDLE`) moves it to `SLOT_ACTIVE` and latches the condition outcome. `SLOT_ACTIVE` holds the enables. The transition *retire* (end-of-execute high in `SLOT_ACTIVE`) returns it to `SLOT_IDLE` and commits any flag update. In every other case the machine stays in its current state.

Top module: `cond_exec_unit`

## Requirements
- R1: After reset, the flags read 0000, `busy` is 0, and both `exec_en` and `reg_wr_en` are 0. Whenever `busy` is 0, both enables are 0.
- R2: An `issue` sampled high while idle sets `busy` from the next cycle on. An `exec_done` sampled high while busy clears `busy` on the next cycle, including the case where `exec_done` arrives in the first busy cycle.
- R3: The condition codes pass as follows, with `flags` bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. 0000 when Z=1. 0001 when Z=0. 0010 when C=1. 0011 when C=0. 0100 when N=1. 0101 when N=0. 0110 when V=1. 0111 when V=0. 1000 when C=1 and Z=0. 1001 when C=0 or Z=1. 1010 when N=V. 1011 when N≠V. 1100 when Z=0 and N=V. 1101 when Z=1 or N≠V. 1110 always passes, and serves as the default for an instruction with no condition.
- R4: Code 1111 never passes, whatever the flags.
- R5: A failing instruction holds `exec_en` and `reg_wr_en` at 0 for its whole slot, still keeps `busy` high until `exec_done`, and leaves the flags unchanged. `reg_wr_en` is never 1 while `exec_en` is 0.
- R6: A passing non-compare instruction with `set_flags`=1 drives `exec_en`=1 and `reg_wr_en`=1, and on the retire edge loads {N,Z,C,V} from the ALU flag inputs.
- R7: A passing non-compare instruction with `set_flags`=0 writes its register, but the ALU flag inputs are ignored and the flags keep their value.
- R8: A passing compare (`compare_op`=1) loads the flags on retire whatever `set_flags` is, drives `exec_en`=1 and holds `reg_wr_en` at 0.
- R9: An `exec_done` that arrives while idle has no effect. The flags and `busy` are unchanged.
- R10: An `issue` that arrives while busy is ignored. The running slot keeps its enables and ends on its own `exec_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | New instruction present; accepted only when idle |
| cond_code | input | 4 | Condition field of the issued instruction |
| set_flags | input | 1 | Flag-update bit of the issued instruction |
| compare_op | input | 1 | Issued instruction is compare-class |
| alu_n | input | 1 | ALU negative result flag |
| alu_z | input | 1 | ALU zero result flag |
| alu_c | input | 1 | ALU carry flag |
| alu_v | input | 1 | ALU overflow flag |
| exec_done | input | 1 | End-of-execute strobe that retires the slot |
| busy | output | 1 | A slot is in progress |
| exec_en | output | 1 | Instruction passed its condition; gates all writes |
| reg_wr_en | output | 1 | Result register write allowed |
| flags | output | 4 | Stored flags {N,Z,C,V} |

## Verification
Enables and `busy` appear one cycle after the accepting edge, and updated flags appear one cycle after the retiring edge. The driver task pushes the expected enables and the expected flag value when it issues an instruction. The monitor samples on falling edges: it checks the enables at the first falling edge where `busy` is newly high, and it checks the flags at the first falling edge where `busy` has just dropped. The expected values come from a condition model in the bench that tracks the flags independently. The ignored-input cases are read back one falling edge after the stray pulse.

// File: rtl/cexu_pkg.sv
package cexu_pkg;

    localparam int COND_W = 4;
    localparam int FLAG_W = 4;

    // Flag vector bit positions
    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FC = 1;
    localparam int FV = 0;

    typedef enum logic [COND_W-1:0] {
        CC_EQ = 4'b0000,
        CC_NE = 4'b0001,
        CC_CS = 4'b0010,
        CC_CC = 4'b0011,
        CC_MI = 4'b0100,
        CC_PL = 4'b0101,
        CC_VS = 4'b0110,
        CC_VC = 4'b0111,
        CC_HI = 4'b1000,
        CC_LS = 4'b1001,
        CC_GE = 4'b1010,
        CC_LT = 4'b1011,
        CC_GT = 4'b1100,
        CC_LE = 4'b1101,
        CC_AL = 4'b1110,
        CC_NV = 4'b1111
    } cond_e;

    typedef enum logic [0:0] {
        SLOT_IDLE   = 1'b0,
        SLOT_ACTIVE = 1'b1
    } slot_state_e;

    typedef struct packed {
        logic pass;
        logic is_cmp;
        logic upd;
    } slot_info_t;

endpackage

// File: rtl/cexu_cond_eval.sv
module cexu_cond_eval
    import cexu_pkg::*;
(
    input  logic [COND_W-1:0] code,
    input  logic [FLAG_W-1:0] flg,
    output logic              pass
);
    logic n, z, c, v;
    logic base;

    assign n = flg[FN];
    assign z = flg[FZ];
    assign c = flg[FC];
    assign v = flg[FV];

    // Codes pair up: even code tests a predicate, odd code its inverse,
    // except the last pair (always / never).
    always_comb begin
        unique case (code[COND_W-1:1])
            3'd0: base = z;
            3'd1: base = c;
            3'd2: base = n;
            3'd3: base = v;
            3'd4: base = c & ~z;
            3'd5: base = ~(n ^ v);
            3'd6: base = ~z & ~(n ^ v);
            default: base = 1'b1;
        endcase
    end

    always_comb begin
        if (code[COND_W-1:1] == 3'd7) begin
            pass = ~code[0];
        end else begin
            pass = base ^ code[0];
        end
    end
endmodule

// File: rtl/cexu_flag_reg.sv
module cexu_flag_reg
    import cexu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FLAG_W-1:0] din,
    output logic [FLAG_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
    import cexu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [COND_W-1:0] cond_code,
    input  logic              set_flags,
    input  logic              compare_op,
    input  logic              alu_n,
    input  logic              alu_z,
    input  logic              alu_c,
    input  logic              alu_v,
    input  logic              exec_done,
    output logic              busy,
    output logic              exec_en,
    output logic              reg_wr_en,
    output logic [FLAG_W-1:0] flags
);
    slot_state_e state_q, state_d;
    slot_info_t  info_q;
    logic        cond_pass;
    logic        accept;
    logic        retire;
    logic        flag_load;
    logic [FLAG_W-1:0] alu_flags;

    assign alu_flags = {alu_n, alu_z, alu_c, alu_v};

    cexu_cond_eval u_eval (
        .code (cond_code),
        .flg  (flags),
        .pass (cond_pass)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        retire  = 1'b0;
        unique case (state_q)
            SLOT_IDLE: begin
                if (issue) begin
                    accept  = 1'b1;
                    state_d = SLOT_ACTIVE;
                end
            end
            SLOT_ACTIVE: begin
                if (exec_done) begin
                    retire  = 1'b1;
                    state_d = SLOT_IDLE;
                end
            end
            default: state_d = SLOT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Slot information captured on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            info_q <= '0;
        end else if (accept) begin
            info_q.pass   <= cond_pass;
            info_q.is_cmp <= compare_op;
            info_q.upd    <= set_flags | compare_op;
        end
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        exec_en   = 1'b0;
        reg_wr_en = 1'b0;
        unique case (state_q)
            SLOT_IDLE: ;
            SLOT_ACTIVE: begin
                busy      = 1'b1;
                exec_en   = info_q.pass;
                reg_wr_en = info_q.pass & ~info_q.is_cmp;
            end
            default: ;
        endcase
    end

    assign flag_load = retire & info_q.pass & info_q.upd;

    cexu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (flag_load),
        .din   (alu_flags),
        .q     (flags)
    );
endmodule

// File: rtl/cond_exec_unit_chk.sv
module cond_exec_unit_chk
    import cexu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              issue,
    input logic [COND_W-1:0] cond_code,
    input logic              exec_done,
    input logic              busy,
    input logic              exec_en,
    input logic              reg_wr_en,
    input logic [FLAG_W-1:0] flags
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!exec_en && !reg_wr_en));

    // R2
    retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && exec_done) |=> !busy);

    // R3
    always_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && issue && cond_code == 4'b1110) |=> (busy && exec_en));

    // R4
    never_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && issue && cond_code == 4'b1111) |=> (busy && !exec_en));

    // R5
    wr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> exec_en);

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !exec_done) |=> $stable(flags));

    // R9
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !issue && exec_done) |=> ($stable(flags) && !busy));

    // R10
    slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !exec_done) |=> (busy && $stable(exec_en) && $stable(reg_wr_en)));
endmodule

bind cond_exec_unit cond_exec_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .cond_code (cond_code),
    .exec_done (exec_done),
    .busy      (busy),
    .exec_en   (exec_en),
    .reg_wr_en (reg_wr_en),
    .flags     (flags)
);

// File: tb/sim_cond_exec_unit.sv
module sim_cond_exec_unit;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue = 1'b0;
    logic [3:0] cond_code = 4'b1110;
    logic       set_flags = 1'b0;
    logic       compare_op = 1'b0;
    logic [3:0] alu = 4'b0000;
    logic       exec_done = 1'b0;
    logic       busy, exec_en, reg_wr_en;
    logic [3:0] flags;

    int checks = 0;
    int failures = 0;
    logic [3:0] model = 4'b0000;

    typedef struct {
        logic       en;
        logic       wr;
        logic [3:0] flg;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .issue(issue), .cond_code(cond_code),
        .set_flags(set_flags), .compare_op(compare_op),
        .alu_n(alu[3]), .alu_z(alu[2]), .alu_c(alu[1]), .alu_v(alu[0]),
        .exec_done(exec_done), .busy(busy), .exec_en(exec_en),
        .reg_wr_en(reg_wr_en), .flags(flags)
    );

    function automatic logic cond_ref(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, c, v;
        n = f[3]; z = f[2]; c = f[1]; v = f[0];
        case (cc)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;
            4'd9:  return !c || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: issues one slot and pushes its expectation
    task automatic run_slot(input logic [3:0] cc, input logic s, input logic cmp,
                            input logic [3:0] a, input int hold, input logic poke,
                            input string tag);
        exp_t e;
        logic p;
        p = cond_ref(cc, model);
        e.en  = p;
        e.wr  = p && !cmp;
        e.flg = (p && (s || cmp)) ? a : model;
        e.tag = tag;
        @(negedge clk);
        sb.push_back(e);
        issue = 1'b1; cond_code = cc; set_flags = s; compare_op = cmp; alu = a;
        @(negedge clk);
        issue = 1'b0;
        for (int i = 0; i < hold; i++) begin
            if (poke && i == 0) begin
                issue = 1'b1; cond_code = 4'b1111; compare_op = 1'b1; set_flags = 1'b1;
                @(negedge clk);
                issue = 1'b0;
                // R10: stray issue leaves the running slot untouched
                check("R10 enable kept", {6'd0, exec_en, busy}, {6'd0, e.en, 1'b1});
            end else begin
                @(negedge clk);
            end
        end
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
        model = e.flg;
    endtask

    // Monitor: compares design results against queued expectations
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !prev_busy) begin
                if (sb.size() == 0) begin
                    check("R10 unexpected slot", 8'd1, 8'd0);
                end else begin
                    check({sb[0].tag, " enables"}, {6'd0, exec_en, reg_wr_en},
                          {6'd0, sb[0].en, sb[0].wr});
                end
            end
            if (!busy && prev_busy && sb.size() != 0) begin
                check({sb[0].tag, " flags"}, {4'd0, flags}, {4'd0, sb[0].flg});
                void'(sb.pop_front());
            end
        end
        prev_busy = busy;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset", {2'd0, busy, exec_en, flags}, 8'h00);
        check("R1 reset wr", {7'd0, reg_wr_en}, 8'h00);

        // R6: flag update with set bit, R2 with immediate retire
        run_slot(4'b1110, 1'b1, 1'b0, 4'b1010, 0, 1'b0, "R6 R2");
        // R7: no update without set bit
        run_slot(4'b1110, 1'b0, 1'b0, 4'b0101, 2, 1'b0, "R7");
        // R8: compare updates without set bit, no register write
        run_slot(4'b1110, 1'b0, 1'b1, 4'b0101, 1, 1'b0, "R8");
        // R5: failing compare with set bit leaves flags (Z=1 now, NE fails)
        run_slot(4'b0001, 1'b1, 1'b1, 4'b1111, 2, 1'b0, "R5");
        // R10: stray issue during a slot
        run_slot(4'b1110, 1'b1, 1'b0, 4'b0110, 3, 1'b1, "R10");

        // R9: strobe while idle
        @(negedge clk);
        alu = ~model; exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
        check("R9 idle strobe", {3'd0, busy, flags}, {4'd0, model});

        // R3 / R4: every code against every flag state
        for (int f = 0; f < 16; f++) begin
            run_slot(4'b1110, 1'b0, 1'b1, 4'(f), 0, 1'b0, "R8 load");
            for (int cc = 0; cc < 16; cc++) begin
                run_slot(4'(cc), 1'b0, 1'b0, 4'(~f), 1, 1'b0,
                         (cc == 15) ? "R4" : "R3");
            end
        end

        repeat (3) @(negedge clk);
        check("R2 queue drained", 8'(sb.size()), 8'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule